// File: doc/BRIEF.md
# Phase-Driven Seven-Segment LCD Driver

This block turns a held numeric reading into the drive pattern for a three-and-a-half digit liquid crystal panel with one shared backplane. The reading arrives as three BCD digits (units, tens, hundreds), a flag that says the leading half digit shows "1", and a sign bit. A load strobe copies these into a display register, so a converter can update its inputs freely while the panel keeps showing the last complete result.

Each segment line is not driven as a static level. The block generates a square-wave backplane that inverts after a set number of rate ticks. A segment that is dark follows the backplane exactly. A segment that is lit carries the inverse of the backplane. Every line therefore toggles with a 50% duty cycle, and no DC voltage builds up across the glass. The leading half digit has a single line that lights its two right-hand bars together. A separate line drives the minus sign. A test input lights every line at once.

Top module: `lcd_bp_driver`

## Requirements
- R1: The display register updates only on a clock edge where `load` is 1. With `load` at 0, changes on the reading inputs leave all segment lines unchanged.
- R2: Each segment bus is ordered bit 0 = a, bit 1 = b, up through bit 6 = g. The lit masks for codes 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R3: BCD codes 10 to 15 light no segment of that digit.
- R4: `seg_lead` is lit exactly when the latched leading-one flag is 1.
- R5: `seg_minus` is lit exactly when the latched sign bit is 1.
- R6: A dark line equals `bp`, and a lit line equals the inverse of `bp`. When `bp` inverts and nothing else changes, every line inverts in the same cycle.
- R7: `bp` inverts on the clock edge that accepts the HALF_TICKS-th `bp_tick` pulse since its last inversion (HALF_TICKS defaults to 4). Without a tick, `bp` holds.
- R8: While `lamp_test` is 1, all 23 lines are lit in that same cycle, whatever is latched. Releasing it brings back the latched pattern.
- R9: After reset, `bp` is 0, the tick count is 0, all three digits are blank, and the lead and minus lines are dark. Every line therefore reads 0.
- R10: With a fixed reading and a tick on every cycle, every line is high for exactly HALF_TICKS cycles in any window of 2*HALF_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture the reading into the display register |
| bcd_ones | input | 4 | Units digit, BCD |
| bcd_tens | input | 4 | Tens digit, BCD |
| bcd_huns | input | 4 | Hundreds digit, BCD |
| lead_one | input | 1 | Leading half digit shows 1 |
| neg | input | 1 | Reading is negative |
| lamp_test | input | 1 | Light every line |
| bp_tick | input | 1 | Backplane rate tick |
| seg_ones | output | 7 | Units segment lines, a..g |
| seg_tens | output | 7 | Tens segment lines, a..g |
| seg_huns | output | 7 | Hundreds segment lines, a..g |
| seg_lead | output | 1 | Combined line for the leading "1" |
| seg_minus | output | 1 | Minus sign line |
| bp | output | 1 | Backplane square wave |

## Verification
A corrupted display register shows up at the ports in the cycle after the bad capture, as a wrong glyph whose phase relative to `bp` is off. It stays wrong until the next load, so holding inputs while `load` is low exposes any leak through the register. A tick counter that drifts moves the `bp` inversion by at least one cycle, and the DC balance count over a 2*HALF_TICKS window then fails at once. A phase inversion error gives a line that matches `bp` when it should oppose it, and this is visible in the first cycle the segment is lit.

// File: rtl/lcdd_pkg.sv
package lcdd_pkg;

    localparam int SEGS       = 7;
    localparam int NUM_DIGITS = 3;
    localparam int NLINES     = NUM_DIGITS * SEGS + 2;

    localparam logic [3:0] BLANK_CODE = 4'hF;

    typedef logic [SEGS-1:0] seg7_t;

    typedef struct packed {
        logic [3:0] huns;
        logic [3:0] tens;
        logic [3:0] ones;
        logic       lead;
        logic       neg;
    } reading_t;

    // bit 0 = a ... bit 6 = g; non-decimal codes blank
    function automatic seg7_t bcd_glyph(input logic [3:0] code);
        seg7_t m;
        case (code)
            4'd0:    m = 7'b0111111;
            4'd1:    m = 7'b0000110;
            4'd2:    m = 7'b1011011;
            4'd3:    m = 7'b1001111;
            4'd4:    m = 7'b1100110;
            4'd5:    m = 7'b1101101;
            4'd6:    m = 7'b1111101;
            4'd7:    m = 7'b0000111;
            4'd8:    m = 7'b1111111;
            4'd9:    m = 7'b1101111;
            default: m = 7'b0000000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lcdd_latch.sv
module lcdd_latch
    import lcdd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  reading_t d_in,
    output reading_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.huns <= BLANK_CODE;
            q.tens <= BLANK_CODE;
            q.ones <= BLANK_CODE;
            q.lead <= 1'b0;
            q.neg  <= 1'b0;
        end else if (load) begin
            q <= d_in;
        end
    end
endmodule

// File: rtl/lcdd_bpgen.sv
module lcdd_bpgen #(
    parameter int HALF_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic bp
);
    localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt <= '0;
                bp  <= ~bp;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcdd_decode.sv
module lcdd_decode
    import lcdd_pkg::*;
(
    input  reading_t          rd,
    input  logic              lamp,
    output logic [NLINES-1:0] on_mask
);
    logic [3:0]  digit [NUM_DIGITS];
    logic [NUM_DIGITS*SEGS-1:0] glyphs;

    assign digit[0] = rd.ones;
    assign digit[1] = rd.tens;
    assign digit[2] = rd.huns;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        assign glyphs[i*SEGS +: SEGS] = bcd_glyph(digit[i]);
    end

    always_comb begin
        if (lamp) on_mask = '1;
        else      on_mask = {rd.neg, rd.lead, glyphs};
    end
endmodule

// File: rtl/lcdd_phase.sv
module lcdd_phase #(
    parameter int W = 23
) (
    input  logic [W-1:0] on_mask,
    input  logic         bp,
    output logic [W-1:0] lines
);
    for (genvar i = 0; i < W; i++) begin : g_line
        assign lines[i] = on_mask[i] ? ~bp : bp;
    end
endmodule

// File: rtl/lcd_bp_driver.sv
module lcd_bp_driver
    import lcdd_pkg::*;
#(
    parameter int HALF_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] bcd_ones,
    input  logic [3:0] bcd_tens,
    input  logic [3:0] bcd_huns,
    input  logic       lead_one,
    input  logic       neg,
    input  logic       lamp_test,
    input  logic       bp_tick,
    output logic [6:0] seg_ones,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_huns,
    output logic       seg_lead,
    output logic       seg_minus,
    output logic       bp
);
    reading_t          rd_in, rd_q;
    logic [NLINES-1:0] on_mask, lines;
    logic              bp_q;

    assign rd_in = '{huns: bcd_huns, tens: bcd_tens, ones: bcd_ones,
                     lead: lead_one, neg: neg};

    lcdd_latch u_latch (
        .clk (clk), .rst (rst), .load (load), .d_in (rd_in), .q (rd_q)
    );

    lcdd_bpgen #(.HALF_TICKS(HALF_TICKS)) u_bpgen (
        .clk (clk), .rst (rst), .tick (bp_tick), .bp (bp_q)
    );

    lcdd_decode u_decode (
        .rd (rd_q), .lamp (lamp_test), .on_mask (on_mask)
    );

    lcdd_phase #(.W(NLINES)) u_phase (
        .on_mask (on_mask), .bp (bp_q), .lines (lines)
    );

    assign seg_ones  = lines[0 +: SEGS];
    assign seg_tens  = lines[SEGS +: SEGS];
    assign seg_huns  = lines[2*SEGS +: SEGS];
    assign seg_lead  = lines[3*SEGS];
    assign seg_minus = lines[3*SEGS+1];
    assign bp        = bp_q;
endmodule

// File: rtl/lcdd_checker.sv
module lcdd_checker (
    input logic       clk,
    input logic       rst,
    input logic       load,
    input logic       lamp_test,
    input logic       bp_tick,
    input logic [6:0] seg_ones,
    input logic [6:0] seg_tens,
    input logic [6:0] seg_huns,
    input logic       seg_lead,
    input logic       seg_minus,
    input logic       bp
);
    logic [22:0] all_lines;
    assign all_lines = {seg_minus, seg_lead, seg_huns, seg_tens, seg_ones};

    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(bp) && !$past(load) && $stable(lamp_test)) |-> $stable(all_lines)); // R1

    AST_BP_INVERT: assert property (@(posedge clk) disable iff (rst)
        (!$stable(bp) && !$past(load) && $stable(lamp_test)) |-> (all_lines == ~$past(all_lines))); // R6

    AST_BP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bp_tick |=> $stable(bp)); // R7

    AST_LAMP_ALL: assert property (@(posedge clk) disable iff (rst)
        lamp_test |-> (all_lines == {23{~bp}})); // R8
endmodule

bind lcd_bp_driver lcdd_checker u_chk (
    .clk (clk), .rst (rst), .load (load), .lamp_test (lamp_test),
    .bp_tick (bp_tick), .seg_ones (seg_ones), .seg_tens (seg_tens),
    .seg_huns (seg_huns), .seg_lead (seg_lead), .seg_minus (seg_minus),
    .bp (bp)
);

// File: tb/lcd_bp_driver_bench.sv
`timescale 1ns/1ps
module lcd_bp_driver_bench;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst, load, lead_one, neg, lamp_test, bp_tick;
    logic [3:0] bcd_ones, bcd_tens, bcd_huns;
    logic [6:0] seg_ones, seg_tens, seg_huns;
    logic seg_lead, seg_minus, bp;

    always #4 clk = ~clk;

    lcd_bp_driver #(.HALF_TICKS(H)) u_lcd_bp_driver (
        .clk, .rst, .load, .bcd_ones, .bcd_tens, .bcd_huns, .lead_one, .neg,
        .lamp_test, .bp_tick, .seg_ones, .seg_tens, .seg_huns, .seg_lead,
        .seg_minus, .bp
    );

    int checks = 0, fails = 0;
    logic [3:0] m_o, m_t, m_h;
    logic m_lead, m_neg, m_bp;
    int m_cnt;

    function automatic logic [6:0] glyph(input logic [3:0] c);
        case (c)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [23:0] expect_vec();
        logic [22:0] on;
        on = lamp_test ? '1 : {m_neg, m_lead, glyph(m_h), glyph(m_t), glyph(m_o)};
        return {m_bp, on ^ {23{m_bp}}};
    endfunction

    function automatic logic [23:0] actual_vec();
        return {bp, seg_minus, seg_lead, seg_huns, seg_tens, seg_ones};
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic step(input logic ld, input logic [3:0] o, t, h,
                        input logic lo, ng, lt, tk);
        @(negedge clk);
        load = ld; bcd_ones = o; bcd_tens = t; bcd_huns = h;
        lead_one = lo; neg = ng; lamp_test = lt; bp_tick = tk;
        @(posedge clk);
        if (tk) begin
            if (m_cnt == H - 1) begin m_cnt = 0; m_bp = ~m_bp; end
            else m_cnt++;
        end
        if (ld) begin m_o = o; m_t = t; m_h = h; m_lead = lo; m_neg = ng; end
        #2;
    endtask

    initial begin
        #(8 * 100000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst = 1; load = 0; bcd_ones = 0; bcd_tens = 0; bcd_huns = 0;
        lead_one = 0; neg = 0; lamp_test = 0; bp_tick = 0;
        m_o = 4'hF; m_t = 4'hF; m_h = 4'hF; m_lead = 0; m_neg = 0; m_bp = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset", actual_vec(), 24'h0);
        @(negedge clk); rst = 0;

        // R2: all ten glyphs, each digit position
        for (int d = 0; d < 10; d++) begin
            step(1, 4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10), 0, 0, 0, 0);
            check("R2 glyph", actual_vec(), expect_vec());
        end
        // R3: blank codes
        for (int d = 10; d < 16; d++) begin
            step(1, 4'(d), 4'(d), 4'(d), 0, 0, 0, 0);
            check("R3 blank", actual_vec(), {1'b0, 23'h0});
        end
        // R4 / R5: lead and minus
        step(1, 4'd1, 4'd2, 4'd3, 1, 0, 0, 0);
        check("R4 lead on", {23'h0, seg_lead}, 24'h1);
        step(1, 4'd1, 4'd2, 4'd3, 0, 1, 0, 0);
        check("R5 minus on", {22'h0, seg_minus, seg_lead}, 24'h2);
        // R1: inputs change without load
        step(0, 4'd8, 4'd8, 4'd8, 1, 0, 0, 0);
        check("R1 hold", actual_vec(), expect_vec());
        check("R1 hold minus", {23'h0, seg_minus}, 24'h1);
        // R7: bp toggles on the H-th tick only
        for (int k = 0; k < H - 1; k++) step(0, 0, 0, 0, 0, 0, 0, 1);
        check("R7 bp before", {23'h0, bp}, 24'h0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        check("R7 bp toggled", {23'h0, bp}, 24'h1);
        // R6: lit lines inverse of bp
        check("R6 phase", actual_vec(), expect_vec());
        // R8: lamp test
        step(0, 0, 0, 0, 0, 0, 1, 0);
        check("R8 lamp", actual_vec(), {1'b1, 23'h0});
        step(0, 0, 0, 0, 0, 0, 0, 0);
        check("R8 release", actual_vec(), expect_vec());
        // R10: DC balance over 2*H cycles with a tick every cycle
        begin
            int hi_on, hi_off;
            hi_on = 0; hi_off = 0;
            step(1, 4'd1, 4'hF, 4'hF, 0, 0, 0, 1);
            for (int k = 0; k < 2 * H; k++) begin
                step(0, 0, 0, 0, 0, 0, 0, 1);
                hi_on  += int'(seg_ones[1]);
                hi_off += int'(seg_ones[0]);
            end
            check("R10 lit balance", 24'(hi_on), 24'(H));
            check("R10 dark balance", 24'(hi_off), 24'(H));
        end
        // Random mix: R2 R6 R7 R1
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) == 0, 4'($urandom), 4'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 8) == 0, 1'($urandom));
            check("R2/R6/R7 random", actual_vec(), expect_vec());
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule